// File: doc/BRIEF.md
# Paced Parallel Bus Master

This block is a bus master for a configurable parallel interface toward a programmable-logic device. Internal requests arrive on a valid/ready port carrying a write flag, an address and write data. The block turns each request into a sequence of bus slots. It drives address and data buses, active-low read and write strobes, an address-phase marker, a framing output and an optional interface clock. It samples a ready input from the far end, which can stretch a transfer.

A free-running divider sets the slot length, so transfers happen at fixed intervals. All configuration inputs are static while reset is released. Data width, address width, phase split, clock behaviour and frame length are chosen per use. Read results return on a response output in the order the reads were issued. The block has no request buffering: one transfer is in flight at a time, and each transfer is followed by one idle slot.

Top module: `pbus_master`

## Requirements
- R1: A slot lasts `cfg_baud`+1 system clocks. A slot boundary occurs on the first clock after reset and then every `cfg_baud`+1 clocks. `req_ready` is high only in the last cycle of a slot while no transfer is in progress, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge.
- R2: `cfg_dsize` selects the data width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Bits above the selected width are zero on `bus_dout` during a write data phase and on `rsp_rdata`.
- R3: `cfg_asize` selects the address width: 0 gives no address (all zero), 1 gives the low 8 bits, 2 gives the low 16 bits, 3 gives all `AW` bits. Unused high bits read as zero.
- R4: In combined mode (`cfg_split`=0, or `cfg_asize`=0), a transfer starts with a data slot. In that slot the masked address is on `bus_addr`, the write data (or zero for a read) is on `bus_dout`, and one strobe is low.
- R5: In split mode (`cfg_split`=1 and `cfg_asize`≠0), the transfer starts with one address slot. In that slot `bus_adv` is high, the masked address is on `bus_dout`, `bus_addr` is zero and both strobes are high. The data slots follow, with `bus_adv` low.
- R6: `bus_wr_n` is low only during the data slots of a write, and `bus_rd_n` only during those of a read. The two are never low together. Outside transfers, `bus_addr` and `bus_dout` are zero.
- R7: At each slot boundary inside a data phase, a low `bus_rdy` adds another data slot with all bus outputs unchanged. A high `bus_rdy` ends the transfer.
- R8: A read completes at the slot boundary where `bus_rdy` is high. At that edge, `bus_din` (masked per R2) is captured into `rsp_rdata`, and `rsp_valid` is high for exactly the next cycle. Writes produce no response.
- R9: `cfg_clk_mode` 0 holds `bus_clk` low. Mode 1 drives `bus_clk` high in the last cycle of every slot. Mode 2 does the same, but only for slots that belong to a transfer.
- R10: With `cfg_frame_len`=N>0, `bus_frame` rises when the first transfer of a frame is taken and falls when the Nth transfer completes. The frame count also restarts, with `bus_frame` low, at any slot boundary with no transfer in progress and no pending request. With N=0, `bus_frame` stays low.
- R11: While `rst` is high, both strobes are high, and `bus_clk`, `bus_frame`, `bus_adv` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dsize | input | 2 | Data width select |
| cfg_asize | input | 2 | Address width select |
| cfg_clk_mode | input | 2 | Interface clock mode: off, free, gated |
| cfg_split | input | 1 | Separate address and data phases |
| cfg_frame_len | input | FLW | Transfers per frame, 0 disables framing |
| cfg_baud | input | BW | Slot length minus one, in system clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | 32 | Request write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |
| bus_clk | output | 1 | Interface clock |
| bus_frame | output | 1 | Frame marker |
| bus_adv | output | 1 | Address-phase marker in split mode |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | AW | Address bus |
| bus_dout | output | 32 | Outgoing data (address in split address slot) |
| bus_din | input | 32 | Incoming read data |
| bus_rdy | input | 1 | Far-end ready, low stretches |

## Verification
The bench runs a behavioural reference model of slots, phases and frame counts alongside the design. It compares every output on every clock, so an error in the slot counter, phase state or frame count shows up at the ports within one slot. A miscounted divider moves `req_ready` and `bus_clk` at the very next boundary. A wrong phase state shows as an early or missing strobe, or as `bus_adv` held for the wrong slot. A stale frame count shifts the falling edge of `bus_frame` by at least one transfer.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_st_t;

  localparam logic [1:0] CK_OFF   = 2'd0;
  localparam logic [1:0] CK_FREE  = 2'd1;
  localparam logic [1:0] CK_GATED = 2'd2;

  function automatic logic [DW-1:0] data_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    data_mask = 32'h0000_00FF;
      2'd1:    data_mask = 32'h0000_FFFF;
      default: data_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/pbus_baud.sv
module pbus_baud #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] cfg_baud,
  output logic          tick,
  output logic          tick_nxt
);

  logic [BW-1:0] cnt;
  logic [BW-1:0] cnt_d;

  // reload at a boundary, otherwise count down toward the next one
  assign cnt_d    = tick ? cfg_baud : cnt - 1'b1;
  assign tick_nxt = (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt_d;
      tick <= tick_nxt;
    end
  end

  // R1: with a nonzero count two boundaries are never adjacent
  p_slot_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && cfg_baud != '0) |=> !tick);

endmodule

// File: rtl/pbus_frame.sv
module pbus_frame #(
  parameter int FLW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [FLW-1:0] cfg_frame_len,
  input  logic           start,
  input  logic           done,
  input  logic           idle_slot,
  output logic           frame
);

  logic [FLW-1:0] fcnt;
  logic           en;

  assign en = (cfg_frame_len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      frame <= 1'b0;
    end else if (idle_slot) begin
      fcnt  <= '0;
      frame <= 1'b0;
    end else if (start && en) begin
      if (fcnt == '0) frame <= 1'b1;
      fcnt <= fcnt + 1'b1;
    end else if (done && en && fcnt == cfg_frame_len) begin
      fcnt  <= '0;
      frame <= 1'b0;
    end
  end

  // R10: framing disabled keeps the marker low
  p_frame_off_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_frame_len == '0) |-> !frame);

  // R10: the count never runs past the frame size
  p_frame_bound_r10: assert property (@(posedge clk) disable iff (rst)
    en |-> (fcnt <= cfg_frame_len));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_dsize,
  input  logic [1:0]    cfg_asize,
  input  logic [1:0]    cfg_clk_mode,
  input  logic          cfg_split,
  input  logic          tick,
  input  logic          tick_nxt,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_clk,
  output logic          bus_adv,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_rdy,
  output logic          accept,
  output logic          done,
  output logic          idle_slot
);

  seq_st_t       st, st_d;
  logic          is_wr;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] dmask;
  logic [AW-1:0] amask;
  logic [AW-1:0] addr_m;
  logic [DW-1:0] addr_ext;
  logic          use_aph;

  assign dmask   = data_mask(cfg_dsize);
  assign use_aph = cfg_split && (cfg_asize != 2'd0);

  always_comb begin
    case (cfg_asize)
      2'd0:    amask = '0;
      2'd1:    amask = AW'(8'hFF);
      2'd2:    amask = AW'(16'hFFFF);
      default: amask = '1;
    endcase
    addr_m   = req_addr & amask;
    addr_ext = '0;
    addr_ext[AW-1:0] = addr_m;
  end

  assign req_ready = tick && (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign idle_slot = req_ready && !req_valid;

  always_comb begin
    st_d = st;
    done = 1'b0;
    if (tick) begin
      case (st)
        ST_IDLE: if (req_valid) st_d = use_aph ? ST_ADDR : ST_DATA;
        ST_ADDR: st_d = ST_DATA;
        ST_DATA: if (bus_rdy) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      is_wr     <= 1'b0;
      wdata_q   <= '0;
      bus_adv   <= 1'b0;
      bus_wr_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_clk   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_d;
      rsp_valid <= 1'b0;
      case (cfg_clk_mode)
        CK_FREE:  bus_clk <= tick_nxt;
        CK_GATED: bus_clk <= tick_nxt && (st_d != ST_IDLE);
        default:  bus_clk <= 1'b0;
      endcase
      if (accept) begin
        is_wr   <= req_write;
        wdata_q <= req_wdata & dmask;
        if (use_aph) begin
          bus_adv  <= 1'b1;
          bus_dout <= addr_ext;
        end else begin
          bus_addr <= addr_m;
          bus_dout <= req_write ? (req_wdata & dmask) : '0;
          bus_wr_n <= !req_write;
          bus_rd_n <= req_write;
        end
      end else if (tick && st == ST_ADDR) begin
        bus_adv  <= 1'b0;
        bus_dout <= is_wr ? wdata_q : '0;
        bus_wr_n <= !is_wr;
        bus_rd_n <= is_wr;
      end else if (done) begin
        bus_wr_n <= 1'b1;
        bus_rd_n <= 1'b1;
        bus_addr <= '0;
        bus_dout <= '0;
        if (!is_wr) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= bus_din & dmask;
        end
      end
    end
  end

  // R6: read and write strobes are mutually exclusive
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!bus_wr_n && !bus_rd_n));

  // R7: a stretched data slot keeps the bus unchanged
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && st == ST_DATA && !bus_rdy) |=>
      ($stable(bus_wr_n) && $stable(bus_rd_n) && $stable(bus_addr) && $stable(bus_dout)));

  // R8: a response only follows a read strobe
  p_rsp_read_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!bus_rd_n));

  // R5: the end of an address slot opens a data slot
  p_adv_then_data_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_adv) |-> (!bus_wr_n || !bus_rd_n));

  // R9: clock output stays low when disabled
  p_clk_off_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_clk_mode == CK_OFF) |=> !bus_clk);

endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int AW  = 24,
  parameter int BW  = 16,
  parameter int FLW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     cfg_dsize,
  input  logic [1:0]     cfg_asize,
  input  logic [1:0]     cfg_clk_mode,
  input  logic           cfg_split,
  input  logic [FLW-1:0] cfg_frame_len,
  input  logic [BW-1:0]  cfg_baud,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  output logic [31:0]    rsp_rdata,
  output logic           bus_clk,
  output logic           bus_frame,
  output logic           bus_adv,
  output logic           bus_wr_n,
  output logic           bus_rd_n,
  output logic [AW-1:0]  bus_addr,
  output logic [31:0]    bus_dout,
  input  logic [31:0]    bus_din,
  input  logic           bus_rdy
);

  logic tick, tick_nxt;
  logic accept, done, idle_slot;

  pbus_baud #(.BW(BW)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .cfg_baud (cfg_baud),
    .tick     (tick),
    .tick_nxt (tick_nxt)
  );

  pbus_seq #(.AW(AW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cfg_dsize    (cfg_dsize),
    .cfg_asize    (cfg_asize),
    .cfg_clk_mode (cfg_clk_mode),
    .cfg_split    (cfg_split),
    .tick         (tick),
    .tick_nxt     (tick_nxt),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .bus_clk      (bus_clk),
    .bus_adv      (bus_adv),
    .bus_wr_n     (bus_wr_n),
    .bus_rd_n     (bus_rd_n),
    .bus_addr     (bus_addr),
    .bus_dout     (bus_dout),
    .bus_din      (bus_din),
    .bus_rdy      (bus_rdy),
    .accept       (accept),
    .done         (done),
    .idle_slot    (idle_slot)
  );

  pbus_frame #(.FLW(FLW)) u_frame (
    .clk           (clk),
    .rst           (rst),
    .cfg_frame_len (cfg_frame_len),
    .start         (accept),
    .done          (done),
    .idle_slot     (idle_slot),
    .frame         (bus_frame)
  );

endmodule

// File: tb/pbus_master_bench.sv
`timescale 1ns/1ps
module pbus_master_bench;

  typedef struct packed {
    logic        w;
    logic [23:0] a;
    logic [31:0] d;
  } rq_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_dsize = 2'd2, cfg_asize = 2'd3, cfg_clk_mode = 2'd1;
  logic        cfg_split = 1'b0;
  logic [7:0]  cfg_frame_len = 8'd0;
  logic [15:0] cfg_baud = 16'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] bus_din = '0;
  logic        bus_rdy = 1'b1;
  logic        req_ready, rsp_valid, bus_clk, bus_frame, bus_adv, bus_wr_n, bus_rd_n;
  logic [31:0] rsp_rdata, bus_dout;
  logic [23:0] bus_addr;

  pbus_master u_pbus_master (
    .clk(clk), .rst(rst), .cfg_dsize(cfg_dsize), .cfg_asize(cfg_asize),
    .cfg_clk_mode(cfg_clk_mode), .cfg_split(cfg_split), .cfg_frame_len(cfg_frame_len),
    .cfg_baud(cfg_baud), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_clk(bus_clk),
    .bus_frame(bus_frame), .bus_adv(bus_adv), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, rdy_mode = 0;
  int reads_sent = 0, rsp_seen = 0, wr_run = 0, wr_run_max = 0;
  rq_t q[$];

  // reference model state
  int          m_cnt, m_st, m_fc;
  bit          m_tick, m_wr, m_adv, m_wrn, m_rdn, m_rv, m_clk, m_frame, m_acc;
  logic [31:0] m_wd, m_dout, m_rd;
  logic [23:0] m_addr;

  function automatic logic [31:0] dm();
    if (cfg_dsize == 2'd0) return 32'hFF;
    if (cfg_dsize == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [23:0] am();
    if (cfg_asize == 2'd0) return 24'h0;
    if (cfg_asize == 2'd1) return 24'hFF;
    if (cfg_asize == 2'd2) return 24'hFFFF;
    return 24'hFF_FFFF;
  endfunction

  always @(posedge clk) begin
    int  ncnt, nst;
    bit  ntick, acc, fin, clr, aph;
    if (rst) begin
      m_cnt = 0; m_tick = 1; m_st = 0; m_fc = 0; m_wr = 0; m_adv = 0;
      m_wrn = 1; m_rdn = 1; m_rv = 0; m_clk = 0; m_frame = 0; m_acc = 0;
      m_wd = 0; m_dout = 0; m_rd = 0; m_addr = 0;
    end else begin
      ncnt  = m_tick ? int'(cfg_baud) : m_cnt - 1;
      ntick = (ncnt == 0);
      acc   = req_valid && m_tick && m_st == 0;
      fin   = m_tick && m_st == 2 && bus_rdy;
      clr   = m_tick && m_st == 0 && !req_valid;
      aph   = cfg_split && cfg_asize != 2'd0;
      nst   = m_st;
      m_rv  = 0;
      if (acc) begin
        m_wr = req_write;
        m_wd = req_wdata & dm();
        if (aph) begin
          nst = 1; m_adv = 1; m_dout = {8'h0, req_addr & am()};
        end else begin
          nst = 2; m_addr = req_addr & am();
          m_dout = req_write ? (req_wdata & dm()) : 32'h0;
          m_wrn = !req_write; m_rdn = req_write;
        end
      end else if (m_tick && m_st == 1) begin
        nst = 2; m_adv = 0; m_dout = m_wr ? m_wd : 32'h0;
        m_wrn = !m_wr; m_rdn = m_wr;
      end else if (fin) begin
        nst = 0; m_wrn = 1; m_rdn = 1; m_addr = 0; m_dout = 0;
        if (!m_wr) begin m_rv = 1; m_rd = bus_din & dm(); end
      end
      if (clr) begin
        m_fc = 0; m_frame = 0;
      end else if (acc && cfg_frame_len != 0) begin
        if (m_fc == 0) m_frame = 1;
        m_fc = m_fc + 1;
      end else if (fin && cfg_frame_len != 0 && m_fc == int'(cfg_frame_len)) begin
        m_fc = 0; m_frame = 0;
      end
      if (cfg_clk_mode == 2'd1)      m_clk = ntick;
      else if (cfg_clk_mode == 2'd2) m_clk = ntick && nst != 0;
      else                           m_clk = 0;
      m_cnt = ncnt; m_tick = ntick; m_st = nst; m_acc = acc;
    end
  end

  task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h cyc=%0d", req, nm, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (rst) begin
      chk("R11", "wr_n", {31'h0, bus_wr_n}, 32'h1);
      chk("R11", "rd_n", {31'h0, bus_rd_n}, 32'h1);
      chk("R11", "clk/frame/adv/rsp",
          {28'h0, bus_clk, bus_frame, bus_adv, rsp_valid}, 32'h0);
    end else begin
      chk("R1", "req_ready", {31'h0, req_ready}, {31'h0, m_tick && m_st == 0});
      chk("R3", "bus_addr", {8'h0, bus_addr}, {8'h0, m_addr});
      chk("R2", "bus_dout", bus_dout, m_dout);
      chk("R5", "bus_adv", {31'h0, bus_adv}, {31'h0, m_adv});
      chk("R6", "strobes", {30'h0, bus_wr_n, bus_rd_n}, {30'h0, m_wrn, m_rdn});
      chk("R8", "rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
      chk("R8", "rsp_rdata", rsp_rdata, m_rd);
      chk("R9", "bus_clk", {31'h0, bus_clk}, {31'h0, m_clk});
      chk("R10", "bus_frame", {31'h0, bus_frame}, {31'h0, m_frame});
      if (rsp_valid) rsp_seen++;
      if (!bus_wr_n) wr_run++; else wr_run = 0;
      if (wr_run > wr_run_max) wr_run_max = wr_run;
    end
    if (m_acc) begin
      void'(q.pop_front());
      m_acc = 0;
    end
    req_valid = (q.size() > 0) && !rst;
    if (q.size() > 0) begin
      req_write = q[0].w; req_addr = q[0].a; req_wdata = q[0].d;
    end
    bus_din = (cyc * 32'h0103_0507) ^ 32'hA5A5_5A5A;
    bus_rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 5) != 1 && (cyc % 5) != 2);
  endtask

  task automatic add(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      rq_t r;
      r.w = ((i + seed) % 3) != 1;
      r.a = 24'hC3A5E1 ^ 24'(i * 24'h01F2D3 + seed);
      r.d = 32'hDEAD_BEEF + 32'(i) * 32'h1111_1111 + 32'(seed);
      if (!r.w) reads_sent++;
      q.push_back(r);
    end
  endtask

  task automatic drain();
    while (q.size() > 0 || m_st != 0) step();
    repeat (4 * (int'(cfg_baud) + 1) + 2) step();
  endtask

  task automatic phase(input logic [1:0] ds, input logic [1:0] as, input logic [1:0] cm,
                       input logic sp, input logic [7:0] fl, input logic [15:0] bd, input int rm);
    rst = 1'b1;
    cfg_dsize = ds; cfg_asize = as; cfg_clk_mode = cm; cfg_split = sp;
    cfg_frame_len = fl; cfg_baud = bd; rdy_mode = rm;
    repeat (3) step();
    rst = 1'b0;
    reads_sent = 0; rsp_seen = 0; wr_run = 0; wr_run_max = 0;
  endtask

  initial begin
    // combined phases, free clock, full sizes, no stretching
    phase(2'd2, 2'd3, 2'd1, 1'b0, 8'd0, 16'd0, 0);
    add(8, 0);
    drain();
    chk("R8", "response count", 32'(rsp_seen), 32'(reads_sent));

    // split phases, 8-bit data and address, gated clock, frames of 3, stretching
    phase(2'd0, 2'd1, 2'd2, 1'b1, 8'd3, 16'd2, 1);
    add(7, 1);
    drain();
    chk("R8", "response count", 32'(rsp_seen), 32'(reads_sent));
    chk("R7", "write strobe outlasts one slot", 32'(wr_run_max > 3), 32'h1);

    // 16-bit, clock off, frames of 2 with a pause that restarts the frame
    phase(2'd1, 2'd2, 2'd0, 1'b0, 8'd2, 16'd1, 1);
    add(3, 2);
    drain();
    add(3, 5);
    drain();
    chk("R8", "response count", 32'(rsp_seen), 32'(reads_sent));

    // split requested but no address: combined, frames of 1, slow slots
    phase(2'd3, 2'd0, 2'd2, 1'b1, 8'd1, 16'd3, 0);
    add(6, 4);
    drain();
    chk("R4", "response count", 32'(rsp_seen), 32'(reads_sent));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired cyc=%0d", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule